// File: doc/BRIEF.md
# Gate-Driver Fault and Soft-Off Sequencer

This block is the synchronous protection controller that sits beside a half-bridge gate driver. It takes already digitized condition flags: an over-current comparator result, a low-side supply undervoltage flag whose hysteresis is handled upstream, an active-low shutdown request, and the sensed level of a fault line that is shared by several drivers. It drives four outputs. One enables the open-drain pull-down on that line. One disables the low-side output. One asks the analog stage for a soft (current-limited) turn-off. The last overrides the dead-time guard while a fault is in progress.

Over-current and undervoltage events each pass through their own glitch filter. A confirmed event, or a shutdown request, produces a stretched, retriggerable pulse on the fault line. An over-current fault turns the low side off softly after a programmable delay. An undervoltage fault, a shutdown request, or another device holding the shared line low turns it off at once. The disable is latched. It clears cycle by cycle: the pulse must be over, every cause must be gone, and the low-side command must have been seen low.

All filter lengths, the pulse length and the soft-off delay are counts of clock cycles, set by parameters.

Top module: `gdf_fault_seq`

## Requirements
- R1: An over-current event is confirmed only at the clock edge where `oc_flag` has been sampled high at OC_FILT consecutive edges. A shorter run changes no output, and the run count restarts from zero whenever the flag is sampled low.
- R2: An undervoltage event is confirmed after UV_FILT consecutive high samples of `uv_flag`, and a shorter run has no effect. On confirmation, `fault_pull` and `lo_disable` are both high in the next cycle. While `uv_flag` stays high after confirmation, `lo_disable` cannot be released.
- R3: `fault_pull` rises only in the cycle after a trigger: a confirmed over-current, a confirmed undervoltage, or `shdn_n` sampled low. It then stays high for exactly PULSE_LEN cycles, and each further trigger restarts that count.
- R4: While `shdn_n` is sampled low, `fault_pull` and `lo_disable` are high from the next cycle on. After `shdn_n` returns high, `fault_pull` stays high for PULSE_LEN more cycles.
- R5: After a confirmed over-current, `lo_disable` and `softoff_req` rise exactly SOFT_DLY cycles after `fault_pull` rises.
- R6: When `fault_line_in` is sampled low (0 = line pulled low) while `fault_pull` is low, `lo_disable` is high in the next cycle. This does not assert `fault_pull`.
- R7: The block's own pull-down is masked from its readback. While the block itself holds the line low during the soft-off delay, `lo_disable` stays low.
- R8: `lo_disable` clears at the first edge where all of the following hold: `fault_pull` was already low, no soft-off delay is pending, no cause is active, and `lo_cmd` has been sampled low at some edge (the current one included) at which `lo_disable` was already high. If `lo_cmd` stays high, the disable stays latched.
- R9: `softoff_req` rises and falls in the same cycles as `lo_disable`.
- R10: `dt_guard_dis` is high whenever `lo_disable` is high, and also for the whole soft-off delay window, starting in the cycle in which `fault_pull` rises on an over-current.
- R11: While `rst_n` is low, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_flag | input | 1 | Over-current comparator flag, high = sense voltage above reference |
| uv_flag | input | 1 | Low-side supply undervoltage flag, high = undervoltage |
| shdn_n | input | 1 | Shutdown request, active low |
| fault_line_in | input | 1 | Sensed level of the shared fault line, 0 = pulled low |
| lo_cmd | input | 1 | Low-side gate command |
| fault_pull | output | 1 | Enable of the open-drain pull-down on the fault line |
| lo_disable | output | 1 | Latched low-side disable |
| softoff_req | output | 1 | Request for soft turn-off of the low side |
| dt_guard_dis | output | 1 | Dead-time guard override while a fault is in progress |

## Verification
The assertions take every input to be a clean, synchronous level that is sampled once per edge. They also assume that `fault_line_in` reflects the wired-AND of the block's own pull-down and any outside device, so the line reads low whenever `fault_pull` is high. The stimulus meets this by building the line in the bench from the design's `fault_pull` and a separate outside-pull control, and by changing every input only on the falling clock edge. The random phase varies the lengths of over-current runs around the filter threshold and mixes shutdown, undervoltage and outside pulls, so that causes overlap while a pulse or a delay is pending.

// File: rtl/gdf_pkg.sv
package gdf_pkg;

  // Width needed to hold the count value n (at least one bit).
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // Causes that can set or hold the low-side disable.
  typedef struct packed {
    logic dly_fire;
    logic uv_hit;
    logic uv_conf;
    logic shdn;
    logic ext;
    logic oc_conf;
  } gdf_cause_t;

endpackage

// File: rtl/gdf_glitch_filter.sv
module gdf_glitch_filter #(
  parameter int unsigned LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_i,
  output logic hit_o,
  output logic conf_o
);
  localparam int unsigned W = gdf_pkg::cnt_bits(LEN);
  localparam logic [W-1:0] TOP = W'(LEN);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  // Saturating run counter; any low sample restarts it.
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!flag_i) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (cnt_q != TOP) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hit_o  = flag_i && (cnt_q == TOP - 1'b1);
  assign conf_o = (cnt_q == TOP);
endmodule

// File: rtl/gdf_oneshot.sv
module gdf_oneshot #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic busy_o,
  output logic last_o
);
  localparam int unsigned W = gdf_pkg::cnt_bits(LEN);
  localparam logic [W-1:0] TOP = W'(LEN);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  // Retriggerable down-counter: a load restarts the full length.
  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    if (load_i)              cnt_d = TOP;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == W'(1));
endmodule

// File: rtl/gdf_fault_seq.sv
module gdf_fault_seq #(
  parameter int unsigned OC_FILT   = 30,
  parameter int unsigned UV_FILT   = 1600,
  parameter int unsigned PULSE_LEN = 10000,
  parameter int unsigned SOFT_DLY  = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_flag,
  input  logic uv_flag,
  input  logic shdn_n,
  input  logic fault_line_in,
  input  logic lo_cmd,
  output logic fault_pull,
  output logic lo_disable,
  output logic softoff_req,
  output logic dt_guard_dis
);
  import gdf_pkg::*;

  logic oc_hit, oc_conf, uv_hit, uv_conf;
  logic pulse_busy, pulse_last;
  logic dly_busy, dly_fire;
  logic pulse_load;
  gdf_cause_t cause;
  logic set_c, hold_c, rel_c;
  logic latch_q, latch_d, latch_en;
  logic seen_q, seen_d;

  gdf_glitch_filter #(.LEN(OC_FILT)) u_oc_filt (
    .clk(clk), .rst_n(rst_n), .flag_i(oc_flag), .hit_o(oc_hit), .conf_o(oc_conf)
  );

  gdf_glitch_filter #(.LEN(UV_FILT)) u_uv_filt (
    .clk(clk), .rst_n(rst_n), .flag_i(uv_flag), .hit_o(uv_hit), .conf_o(uv_conf)
  );

  assign pulse_load = oc_hit || uv_hit || !shdn_n;

  gdf_oneshot #(.LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .load_i(pulse_load), .busy_o(pulse_busy), .last_o(pulse_last)
  );

  gdf_oneshot #(.LEN(SOFT_DLY)) u_soft_dly (
    .clk(clk), .rst_n(rst_n), .load_i(oc_hit), .busy_o(dly_busy), .last_o(dly_fire)
  );

  // Cause collection; own pull-down masks the line readback.
  always_comb begin
    cause.dly_fire = dly_fire;
    cause.uv_hit   = uv_hit;
    cause.uv_conf  = uv_conf;
    cause.shdn     = !shdn_n;
    cause.ext      = !fault_line_in && !pulse_busy;
    cause.oc_conf  = oc_conf;
    set_c  = cause.dly_fire || cause.uv_hit || cause.uv_conf ||
             cause.shdn || cause.ext;
    hold_c = set_c || cause.oc_conf;
  end

  // Latch next state and cycle-by-cycle release.
  always_comb begin
    rel_c    = latch_q && (seen_q || !lo_cmd) && !pulse_busy &&
               !dly_busy && !hold_c;
    latch_en = set_c || rel_c;
    latch_d  = set_c;
    seen_d   = latch_q && (seen_q || !lo_cmd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      if (latch_en) latch_q <= latch_d;
      seen_q <= seen_d;
    end
  end

  assign fault_pull   = pulse_busy;
  assign lo_disable   = latch_q;
  assign softoff_req  = latch_q;
  assign dt_guard_dis = latch_q || dly_busy;

  logic unused_ok;
  assign unused_ok = pulse_last;
endmodule

// File: rtl/gdf_fault_seq_chk.sv
module gdf_fault_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic oc_flag,
  input logic uv_flag,
  input logic shdn_n,
  input logic fault_line_in,
  input logic fault_pull,
  input logic lo_disable,
  input logic dt_guard_dis
);
  // R3: the pulse starts only after a trigger cause was sampled.
  p_pulse_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_pull) |-> ($past(oc_flag) || $past(uv_flag) || !$past(shdn_n)))
    else $error("p_pulse_cause_r3");

  // R4: shutdown forces pulse and disable in the next cycle.
  p_shdn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> (fault_pull && lo_disable))
    else $error("p_shdn_r4");

  // R6: line low from outside while not self-driven disables the low side.
  p_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_line_in && !fault_pull) |=> lo_disable)
    else $error("p_ext_r6");

  // R8: release only after the pulse was over and shutdown was inactive.
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lo_disable) |-> ($past(!fault_pull) && $past(shdn_n)))
    else $error("p_release_r8");

  // R10: a pulse started by over-current alone arrives with the guard override.
  p_guard_oc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fault_pull) && !$past(uv_flag) && $past(shdn_n)) |-> dt_guard_dis)
    else $error("p_guard_oc_r10");
endmodule

bind gdf_fault_seq gdf_fault_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .uv_flag(uv_flag),
  .shdn_n(shdn_n), .fault_line_in(fault_line_in), .fault_pull(fault_pull),
  .lo_disable(lo_disable), .dt_guard_dis(dt_guard_dis)
);

// File: tb/tb_gdf_fault_seq.sv
module tb_gdf_fault_seq;
  localparam int CLK_PERIOD = 10;
  localparam int OC = 5;
  localparam int UV = 12;
  localparam int PL = 40;
  localparam int SD = 6;

  logic clk = 1'b0;
  logic rst_n, oc_flag, uv_flag, shdn_n, lo_cmd, ext_pull;
  logic fault_line_in;
  logic fault_pull, lo_disable, softoff_req, dt_guard_dis;

  // Wired-AND fault line: low when either side pulls.
  assign fault_line_in = !(ext_pull || fault_pull);

  gdf_fault_seq #(.OC_FILT(OC), .UV_FILT(UV), .PULSE_LEN(PL), .SOFT_DLY(SD)) dut (
    .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .uv_flag(uv_flag),
    .shdn_n(shdn_n), .fault_line_in(fault_line_in), .lo_cmd(lo_cmd),
    .fault_pull(fault_pull), .lo_disable(lo_disable),
    .softoff_req(softoff_req), .dt_guard_dis(dt_guard_dis)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_en = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Behavioural reference: run lengths and remaining-time integers.
  int m_oc_run, m_uv_run, m_pulse, m_dly;
  bit m_latch, m_seen;

  always @(posedge clk or negedge rst_n) begin
    int oc_new, uv_new;
    bit oc_hit, uv_hit, fire, ext, set, hold, rel, pull_o;
    if (!rst_n) begin
      m_oc_run = 0; m_uv_run = 0; m_pulse = 0; m_dly = 0;
      m_latch = 0; m_seen = 0;
    end else begin
      pull_o = (m_pulse > 0);
      oc_new = oc_flag ? ((m_oc_run + 1 > OC + 1) ? OC + 1 : m_oc_run + 1) : 0;
      uv_new = uv_flag ? ((m_uv_run + 1 > UV + 1) ? UV + 1 : m_uv_run + 1) : 0;
      oc_hit = (oc_new == OC);
      uv_hit = (uv_new == UV);
      fire   = (m_dly == 1);
      ext    = !fault_line_in && !pull_o;
      set    = fire || uv_hit || (m_uv_run >= UV) || !shdn_n || ext;
      hold   = set || (m_oc_run >= OC);
      rel    = m_latch && (m_seen || !lo_cmd) && !pull_o && (m_dly == 0) && !hold;
      m_seen = m_latch && (m_seen || !lo_cmd);
      if (set) m_latch = 1;
      else if (rel) m_latch = 0;
      m_pulse = (oc_hit || uv_hit || !shdn_n) ? PL : ((m_pulse > 0) ? m_pulse - 1 : 0);
      m_dly   = oc_hit ? SD : ((m_dly > 0) ? m_dly - 1 : 0);
      m_oc_run = oc_new;
      m_uv_run = uv_new;
    end
  end

  // Per-cycle comparison against the reference.
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk("R3 fault_pull vs model", int'(fault_pull), int'(m_pulse > 0));
      chk("R8 lo_disable vs model", int'(lo_disable), int'(m_latch));
      chk("R9 softoff_req vs model", int'(softoff_req), int'(m_latch));
      chk("R10 dt_guard_dis vs model", int'(dt_guard_dis), int'(m_latch || m_dly > 0));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int cnt;
    rst_n = 1'b0; oc_flag = 1'b0; uv_flag = 1'b0; shdn_n = 1'b1;
    lo_cmd = 1'b1; ext_pull = 1'b0;
    step(3);
    // R11 reset state
    chk("R11 fault_pull in reset", int'(fault_pull), 0);
    chk("R11 lo_disable in reset", int'(lo_disable), 0);
    chk("R11 softoff_req in reset", int'(softoff_req), 0);
    chk("R11 dt_guard_dis in reset", int'(dt_guard_dis), 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    step(2);

    // R1 short over-current run is ignored
    oc_flag = 1'b1; step(OC - 1); oc_flag = 1'b0; step(3);
    chk("R1 short oc run no pulse", int'(fault_pull), 0);
    chk("R1 short oc run no disable", int'(lo_disable), 0);
    chk("R1 short oc run no guard", int'(dt_guard_dis), 0);

    // R1/R5/R7/R10/R3 confirmed over-current
    oc_flag = 1'b1; step(OC);
    chk("R1 oc confirmed pulse", int'(fault_pull), 1);
    oc_flag = 1'b0;
    cnt = 0;
    for (int k = 0; k < PL + 3; k++) begin
      if (fault_pull) cnt++;
      if (k == SD - 1) begin
        chk("R7 own pull masked during delay", int'(lo_disable), 0);
        chk("R10 guard during delay", int'(dt_guard_dis), 1);
      end
      if (k == SD) begin
        chk("R5 soft-off after delay", int'(lo_disable), 1);
        chk("R9 softoff_req with disable", int'(softoff_req), 1);
      end
      step(1);
    end
    chk("R3 pulse length", cnt, PL);
    chk("R8 latched while lo_cmd high", int'(lo_disable), 1);
    lo_cmd = 1'b0; step(1);
    chk("R8 release after lo_cmd low", int'(lo_disable), 0);
    chk("R9 softoff_req released", int'(softoff_req), 0);
    chk("R10 guard released", int'(dt_guard_dis), 0);

    // R2 undervoltage filter and hold
    lo_cmd = 1'b1;
    uv_flag = 1'b1; step(UV - 1); uv_flag = 1'b0; step(3);
    chk("R2 short uv run no pulse", int'(fault_pull), 0);
    chk("R2 short uv run no disable", int'(lo_disable), 0);
    uv_flag = 1'b1; step(UV);
    chk("R2 uv confirmed pulse", int'(fault_pull), 1);
    chk("R2 uv confirmed disable", int'(lo_disable), 1);
    lo_cmd = 1'b0; step(PL + 3);
    chk("R2 disable held while uv", int'(lo_disable), 1);
    uv_flag = 1'b0; step(1);
    chk("R2 disable one cycle after uv drop", int'(lo_disable), 1);
    step(1);
    chk("R8 release after uv gone", int'(lo_disable), 0);

    // R4 shutdown
    shdn_n = 1'b0; step(1);
    chk("R4 shutdown pulse", int'(fault_pull), 1);
    chk("R4 shutdown disable", int'(lo_disable), 1);
    step(2);
    shdn_n = 1'b1; step(PL - 1);
    chk("R4 pulse stretched after shutdown", int'(fault_pull), 1);
    step(1);
    chk("R3 pulse ends after stretch", int'(fault_pull), 0);
    chk("R8 held in cycle pulse ends", int'(lo_disable), 1);
    step(1);
    chk("R8 release cycle after pulse", int'(lo_disable), 0);

    // R6 outside pull on the fault line
    ext_pull = 1'b1; step(1);
    chk("R6 outside pull disables", int'(lo_disable), 1);
    chk("R6 outside pull no own pulse", int'(fault_pull), 0);
    step(2);
    ext_pull = 1'b0; step(1);
    chk("R6 release after outside pull", int'(lo_disable), 0);
    chk("R6 still no own pulse", int'(fault_pull), 0);

    // Mixed random phase, checked cycle by cycle against the reference
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 5) == 0) oc_flag = !oc_flag;
      if ($urandom_range(0, 40) == 0) uv_flag = !uv_flag;
      if ($urandom_range(0, 7) == 0) lo_cmd = !lo_cmd;
      if (shdn_n) begin
        if ($urandom_range(0, 150) == 0) shdn_n = 1'b0;
      end else if ($urandom_range(0, 3) == 0) shdn_n = 1'b1;
      if (!ext_pull) begin
        if ($urandom_range(0, 120) == 0) ext_pull = 1'b1;
      end else if ($urandom_range(0, 4) == 0) ext_pull = 1'b0;
      step(1);
    end

    summary();
    $finish;
  end
endmodule